// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core should take next. It watches five request lines. One is non-maskable and fires on a rising edge, but only while the line is still high. One is captured by a rising edge into a pending flag, and it captures even while masked. Two are level-sensitive restart lines. The last is an external request whose vector is supplied by the device during acknowledge.

The controller combines three things: per-line masks, a global enable, and a fixed priority. At the core's sampling point, or on any clock while the core is halted or holding the bus, the winning request is latched. It is presented with its source code and restart address and held until the core acknowledges it. Each new latch raises a one-cycle wake pulse that brings the core out of power-down.

The core drives two strobes. A mask-write strobe with an 8-bit byte updates the masks, clears the edge flag and sets the serial output bit. A status-read strobe captures a byte holding the masks, the enable, the pending lines and the serial input bit. Acknowledging any request clears the enable. Acknowledging the non-maskable request also saves the enable state it found. The first status read after that reports the saved state instead of the live one.

Top module: `irq_vector_unit`

## Requirements
- R1: After a synchronous reset: `irq_valid`=0, `wake`=0, `serial_out`=0, `stat_data`=0x00, the enable is 0 and all three masks are 1. A status read right after reset therefore returns 0x07.
- R2: When several eligible requests are present at a sampling edge, the one taken follows this order, highest first: `nmi_in`, `edge_in`, `lvl_b_in`, `lvl_a_in`, `ext_in`.
- R3: Each taken request shows on `irq_src` and `irq_vector` as follows.

  | Source | `irq_src` | `irq_vector` | `irq_vec_ext` |
  |---|---|---|---|
  | `nmi_in` | 0 | 0x24 | 0 |
  | `edge_in` | 1 | 0x3C | 0 |
  | `lvl_b_in` | 2 | 0x34 | 0 |
  | `lvl_a_in` | 3 | 0x2C | 0 |
  | `ext_in` | 4 | 0x00 | 1 (vector comes from the acknowledge cycle) |

- R4: A rising edge on `edge_in` sets a pending flag even while that line is masked, and the flag holds after the line falls. Three things clear it: acknowledging that source, a mask-write with bit 4 set, or reset. The line is eligible only when the flag is set, its mask is 0 and the enable is 1.
- R5: `lvl_a_in`, `lvl_b_in` and `ext_in` are eligible only while high at the sampling edge with the enable at 1, and for the first two with their mask at 0. A line that falls before sampling is not taken.
- R6: `nmi_in` ignores the masks and the enable. It is taken only after a rising edge and only while still high at sampling. Once acknowledged, it is not taken again until the line goes low and then high.
- R7: An acknowledge (`ack` while `irq_valid`) clears `irq_valid` and the enable. Acknowledging `nmi_in` also saves the prior enable. The first status read after that reports the saved enable in bit 3; later reads report the live enable.
- R8: A request is latched only on an edge where `sample_en` or `idle_state` is 1 and nothing is already presented. A presented request, its source and its vector stay unchanged until `ack`.
- R9: Mask-write (`cfg_wr`) byte layout:
  - bits 2:0 become the masks of `lvl_a_in`, `lvl_b_in` and `edge_in`, but only when bit 3 is 1;
  - bit 4 = 1 clears the edge flag;
  - bit 7 is copied to `serial_out`, but only when bit 6 is 1.
- R10: Status read (`stat_rd`) captures this byte into `stat_data` on the next edge:
  - bits 2:0 are the masks;
  - bit 3 is the enable;
  - bit 4 is `lvl_a_in`, bit 5 is `lvl_b_in`, bit 6 is the edge flag;
  - bit 7 is `serial_in`.
- R11: `wake` is high for exactly the one cycle following the edge on which a request is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, edge-and-level |
| edge_in | input | 1 | Rising-edge captured restart request |
| lvl_b_in | input | 1 | Level restart request, higher of the two |
| lvl_a_in | input | 1 | Level restart request, lower of the two |
| ext_in | input | 1 | External-vector level request |
| sample_en | input | 1 | Core sampling point (next-to-last clock of an instruction) |
| idle_state | input | 1 | Core is halted or holding; sample every clock |
| ack | input | 1 | Core accepts the presented request |
| ie_set | input | 1 | Set the global enable |
| ie_clr | input | 1 | Clear the global enable |
| cfg_wr | input | 1 | Mask-write strobe |
| cfg_data | input | 8 | Mask-write byte |
| stat_rd | input | 1 | Status-read strobe |
| serial_in | input | 1 | Serial input bit |
| stat_data | output | 8 | Captured status byte |
| serial_out | output | 1 | Serial output bit |
| irq_valid | output | 1 | A request is presented |
| irq_src | output | 3 | Source code of the presented request |
| irq_vector | output | 8 | Restart address of the presented request |
| irq_vec_ext | output | 1 | Vector must be taken from the acknowledge cycle |
| wake | output | 1 | One-cycle power-down release pulse |

## Verification
The hardest state to reach is the saved-enable view. It needs a non-maskable acknowledge while the enable is 1, then two status reads in a row whose bit 3 must differ. The stimulus produces it by setting the enable and masking every other line. It then raises `nmi_in` and waits one clock so the edge arms, samples in the idle state, acknowledges, and reads status twice. The same sequence then holds `nmi_in` high to show that no second request is taken, and lowers and raises it to show that one is.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC  = 5;
  localparam int SRC_W = $clog2(NSRC);

  // Index order is the priority order, 0 = highest
  typedef enum logic [SRC_W-1:0] {
    SRC_NMI  = 3'd0,
    SRC_EDGE = 3'd1,
    SRC_LVLB = 3'd2,
    SRC_LVLA = 3'd3,
    SRC_EXT  = 3'd4
  } src_e;

  function automatic logic [7:0] restart_addr(input src_e s);
    case (s)
      SRC_NMI:  restart_addr = 8'h24;
      SRC_EDGE: restart_addr = 8'h3C;
      SRC_LVLB: restart_addr = 8'h34;
      SRC_LVLA: restart_addr = 8'h2C;
      default:  restart_addr = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic edge_in,
  input  logic ack_nmi,
  input  logic ack_edge,
  input  logic edge_clr,
  output logic nmi_arm,
  output logic edge_pend
);
  logic nmi_prev, edge_prev;
  logic nmi_rise, edge_rise;

  assign nmi_rise  = nmi_in  & ~nmi_prev;
  assign edge_rise = edge_in & ~edge_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev  <= 1'b0;
      edge_prev <= 1'b0;
      nmi_arm   <= 1'b0;
      edge_pend <= 1'b0;
    end else begin
      nmi_prev  <= nmi_in;
      edge_prev <= edge_in;
      nmi_arm   <= nmi_rise  | (nmi_arm   & ~ack_nmi);
      edge_pend <= edge_rise | (edge_pend & ~(ack_edge | edge_clr));
    end
  end

  // R4: the captured edge survives until a clearing event
  assert_edge_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (edge_pend && !ack_edge && !edge_clr) |=> edge_pend);

  // R6: a line that stays high cannot re-arm
  assert_nmi_no_rearm_R6: assert property (@(posedge clk) disable iff (rst)
    (!nmi_arm && nmi_prev && nmi_in) |=> !nmi_arm);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic          win_valid,
  output logic [IW-1:0] win_idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        win_valid = 1'b1;
        win_idx   = IW'(i);
      end
    end
    grant = win_valid ? (N'(1) << win_idx) : '0;
  end

  // R2: at most one winner and only among requesters
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~req) == '0));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_data,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              take_ack,
  input  logic              ack_nmi,
  input  logic              stat_rd,
  input  logic              serial_in,
  input  logic [MASK_W-1:0] pend,
  output logic [MASK_W-1:0] mask,
  output logic              ie,
  output logic              serial_out,
  output logic [7:0]        stat_data,
  output logic              edge_clr
);
  logic saved_ie, show_saved;
  logic ie_view;

  assign edge_clr = cfg_wr & cfg_data[4];
  assign ie_view  = show_saved ? saved_ie : ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask       <= '1;
      ie         <= 1'b0;
      serial_out <= 1'b0;
      stat_data  <= '0;
      saved_ie   <= 1'b0;
      show_saved <= 1'b0;
    end else begin
      if (cfg_wr && cfg_data[3]) mask <= cfg_data[MASK_W-1:0];
      if (cfg_wr && cfg_data[6]) serial_out <= cfg_data[7];

      if (take_ack)    ie <= 1'b0;
      else if (ie_clr) ie <= 1'b0;
      else if (ie_set) ie <= 1'b1;

      if (stat_rd) begin
        stat_data  <= {serial_in, pend, ie_view, mask};
        show_saved <= 1'b0;
      end
      if (ack_nmi) begin
        saved_ie   <= ie;
        show_saved <= 1'b1;
      end
    end
  end

  // R7: acceptance always leaves the enable cleared
  assert_ack_clears_ie_R7: assert property (@(posedge clk) disable iff (rst)
    take_ack |=> !ie);
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_in,
  input  logic             edge_in,
  input  logic             lvl_b_in,
  input  logic             lvl_a_in,
  input  logic             ext_in,
  input  logic             sample_en,
  input  logic             idle_state,
  input  logic             ack,
  input  logic             ie_set,
  input  logic             ie_clr,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_data,
  input  logic             stat_rd,
  input  logic             serial_in,
  output logic [7:0]       stat_data,
  output logic             serial_out,
  output logic             irq_valid,
  output logic [2:0]       irq_src,
  output logic [VEC_W-1:0] irq_vector,
  output logic             irq_vec_ext,
  output logic             wake
);
  import irqc_pkg::*;

  logic              nmi_arm, edge_pend, edge_clr, ie;
  logic [2:0]        mask;
  logic [NSRC-1:0]   elig, grant;
  logic              win_valid;
  logic [SRC_W-1:0]  win_idx;
  logic              take, ack_fire, ack_nmi, ack_edge;
  src_e              src_q, win_src;

  assign ack_fire = ack & irq_valid;
  assign ack_nmi  = ack_fire & (src_q == SRC_NMI);
  assign ack_edge = ack_fire & (src_q == SRC_EDGE);

  irqc_capture u_capture (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .edge_in(edge_in),
    .ack_nmi(ack_nmi), .ack_edge(ack_edge), .edge_clr(edge_clr),
    .nmi_arm(nmi_arm), .edge_pend(edge_pend)
  );

  always_comb begin
    elig           = '0;
    elig[SRC_NMI]  = nmi_arm & nmi_in;
    elig[SRC_EDGE] = edge_pend & ~mask[2] & ie;
    elig[SRC_LVLB] = lvl_b_in  & ~mask[1] & ie;
    elig[SRC_LVLA] = lvl_a_in  & ~mask[0] & ie;
    elig[SRC_EXT]  = ext_in & ie;
  end

  irqc_arbiter #(.N(NSRC)) u_arb (
    .clk(clk), .rst(rst), .req(elig),
    .win_valid(win_valid), .win_idx(win_idx), .grant(grant)
  );

  irqc_regs #(.MASK_W(3)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .ie_set(ie_set), .ie_clr(ie_clr), .take_ack(ack_fire), .ack_nmi(ack_nmi),
    .stat_rd(stat_rd), .serial_in(serial_in),
    .pend({edge_pend, lvl_b_in, lvl_a_in}),
    .mask(mask), .ie(ie), .serial_out(serial_out),
    .stat_data(stat_data), .edge_clr(edge_clr)
  );

  assign win_src = src_e'(win_idx);
  assign take    = (sample_en | idle_state) & ~irq_valid & win_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid   <= 1'b0;
      src_q       <= SRC_NMI;
      irq_vector  <= '0;
      irq_vec_ext <= 1'b0;
      wake        <= 1'b0;
    end else begin
      wake <= take;
      if (take) begin
        irq_valid   <= 1'b1;
        src_q       <= win_src;
        irq_vector  <= VEC_W'(restart_addr(win_src));
        irq_vec_ext <= (win_src == SRC_EXT);
      end else if (ack_fire) begin
        irq_valid <= 1'b0;
      end
    end
  end

  assign irq_src = src_q;

  // R8: a presented request holds its identity until acknowledged
  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !ack) |=> (irq_valid && $stable(irq_vector) && $stable(irq_src)));

  // R11: wake only accompanies a freshly latched request
  assert_wake_with_req_R11: assert property (@(posedge clk) disable iff (rst)
    wake |-> (irq_valid && $rose(irq_valid)));

  // R5: maskable sources need the enable at the latching edge
  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_valid) && irq_src != SRC_NMI) |-> $past(ie));
endmodule

// File: tb/test_irq_vector_unit.sv
`timescale 1ns/1ps
module test_irq_vector_unit;
  logic clk = 1'b0;
  logic rst;
  logic nmi_in, edge_in, lvl_b_in, lvl_a_in, ext_in;
  logic sample_en, idle_state, ack, ie_set, ie_clr, cfg_wr, stat_rd, serial_in;
  logic [7:0] cfg_data;
  logic [7:0] stat_data, irq_vector;
  logic [2:0] irq_src;
  logic serial_out, irq_valid, irq_vec_ext, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_unit i_irq_vector_unit (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .edge_in(edge_in),
    .lvl_b_in(lvl_b_in), .lvl_a_in(lvl_a_in), .ext_in(ext_in),
    .sample_en(sample_en), .idle_state(idle_state), .ack(ack),
    .ie_set(ie_set), .ie_clr(ie_clr), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .stat_rd(stat_rd), .serial_in(serial_in), .stat_data(stat_data),
    .serial_out(serial_out), .irq_valid(irq_valid), .irq_src(irq_src),
    .irq_vector(irq_vector), .irq_vec_ext(irq_vec_ext), .wake(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle strobes, outputs checked at the following negedge
  task automatic sample_once();
    sample_en = 1; cyc(); sample_en = 0;
  endtask
  task automatic do_ack();
    ack = 1; cyc(); ack = 0;
  endtask
  task automatic do_ie();
    ie_set = 1; cyc(); ie_set = 0;
  endtask
  task automatic do_cfg(input logic [7:0] d);
    cfg_wr = 1; cfg_data = d; cyc(); cfg_wr = 0; cfg_data = 0;
  endtask
  task automatic do_stat();
    stat_rd = 1; cyc(); stat_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 valid", irq_valid, 0);
    chk("R1 wake", wake, 0);
    chk("R1 serial_out", serial_out, 0);
    chk("R1 stat_data", stat_data, 8'h00);
    do_stat();
    chk("R1 status after reset", stat_data, 8'h07);
  endtask

  task automatic t_sampling();
    do_ie(); do_cfg(8'h08);
    lvl_a_in = 1; cyc(3);
    chk("R8 no latch without sample point", irq_valid, 0);
    idle_state = 1; cyc(); idle_state = 0;
    chk("R8 idle-state latch", irq_valid, 1);
    chk("R3 lvl_a vector", irq_vector, 8'h2C);
    chk("R3 lvl_a src", irq_src, 3);
    chk("R11 wake pulse", wake, 1);
    lvl_a_in = 0; cyc();
    chk("R11 wake one cycle", wake, 0);
    chk("R8 held after line drop", irq_valid, 1);
    chk("R8 vector held", irq_vector, 8'h2C);
    do_ack();
    chk("R7 ack clears valid", irq_valid, 0);
    lvl_a_in = 1; sample_once();
    chk("R7 enable cleared by ack", irq_valid, 0);
    lvl_a_in = 0;
    do_stat();
    chk("R10 enable bit cleared", stat_data, 8'h00);
  endtask

  task automatic t_priority();
    do_ie();
    edge_in = 1; cyc(); edge_in = 0;
    lvl_b_in = 1; lvl_a_in = 1; ext_in = 1; cyc();
    sample_once();
    chk("R2 edge wins", irq_src, 1);
    chk("R3 edge vector", irq_vector, 8'h3C);
    do_ack(); do_ie(); sample_once();
    chk("R2 lvl_b next", irq_src, 2);
    chk("R3 lvl_b vector", irq_vector, 8'h34);
    do_ack(); do_ie(); lvl_b_in = 0; sample_once();
    chk("R2 lvl_a next", irq_src, 3);
    do_ack(); do_ie(); lvl_a_in = 0; sample_once();
    chk("R2 ext last", irq_src, 4);
    chk("R3 ext vector", irq_vector, 8'h00);
    chk("R3 ext flag", irq_vec_ext, 1);
    do_ack(); ext_in = 0;
    do_ie(); lvl_a_in = 1; cyc(); lvl_a_in = 0; sample_once();
    chk("R5 level dropped before sample", irq_valid, 0);
  endtask

  task automatic t_edge_masked();
    do_cfg(8'h0F);
    edge_in = 1; cyc(); edge_in = 0; cyc();
    do_stat();
    chk("R4 edge latched while masked", stat_data, 8'h4F);
    sample_once();
    chk("R4 masked edge not taken", irq_valid, 0);
    do_cfg(8'h08); sample_once();
    chk("R4 unmasked edge taken", irq_vector, 8'h3C);
    do_ack();
    do_stat();
    chk("R4 ack clears edge flag", stat_data, 8'h00);
    edge_in = 1; cyc(); edge_in = 0; cyc();
    do_cfg(8'h10);
    do_stat();
    chk("R4 cfg bit4 clears edge flag", stat_data, 8'h00);
  endtask

  task automatic t_nmi();
    do_ie(); do_cfg(8'h0F);
    nmi_in = 1; cyc(2);
    idle_state = 1; cyc(); idle_state = 0;
    chk("R6 nmi taken despite masks", irq_src, 0);
    chk("R3 nmi vector", irq_vector, 8'h24);
    do_ack();
    sample_once();
    chk("R6 held line not retaken", irq_valid, 0);
    do_stat();
    chk("R7 first read shows saved enable", stat_data, 8'h0F);
    do_stat();
    chk("R7 second read shows live enable", stat_data, 8'h07);
    nmi_in = 0; cyc(); nmi_in = 1; cyc(2); sample_once();
    chk("R6 retaken after low-high, enable off", irq_src, 0);
    chk("R6 valid", irq_valid, 1);
    do_ack(); nmi_in = 0; cyc();
    nmi_in = 1; cyc(); nmi_in = 0; cyc(); sample_once();
    chk("R6 needs level at sample", irq_valid, 0);
  endtask

  task automatic t_serial();
    do_cfg(8'h80);
    chk("R9 serial bit ignored without bit6", serial_out, 0);
    do_cfg(8'hC0);
    chk("R9 serial bit set", serial_out, 1);
    do_cfg(8'h05);
    serial_in = 1; do_stat();
    chk("R9 masks kept without bit3 / R10 serial_in", stat_data, 8'h87);
    do_cfg(8'h4D);
    chk("R9 serial bit cleared", serial_out, 0);
    serial_in = 0; lvl_b_in = 1; do_stat();
    chk("R10 pending level and mask layout", stat_data, 8'h25);
    lvl_b_in = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; nmi_in = 0; edge_in = 0; lvl_b_in = 0; lvl_a_in = 0; ext_in = 0;
    sample_en = 0; idle_state = 0; ack = 0; ie_set = 0; ie_clr = 0;
    cfg_wr = 0; cfg_data = 0; stat_rd = 0; serial_in = 0;
    cyc(3); rst = 0; cyc();
    t_reset();
    t_sampling();
    t_priority();
    t_edge_masked();
    t_nmi();
    t_serial();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule